// File: doc/BRIEF.md
# Row-Organised Fixed Delay Line

This block delays a stream of samples by a fixed number of accepted cycles. Its storage is a memory arranged as `ROWS` rows of `COLS` words, so the capacity equals the delay length `ROWS*COLS`. The read and the write of one cycle share a single row select. The write trails the read by one word, so every location is refilled in the cycle after it was read.

Each row's final word has a second write port. That port is selected by the next row's select, and the last row's final word is selected by the first row's select. When the read pointer has just moved into a new row, the sample that belongs at the end of the previous row can still be stored. The output carries nothing until every location holds a real sample. After that, every accepted sample pushes out the oldest one.

Top module: `rowdelay_line`

## Requirements
- R1: After reset, `out_valid` stays 0 until `DELAY = ROWS*COLS` samples have been accepted. Its first rise is in the cycle after the DELAY-th accepted sample.
- R2: Once filled, the cycle after the n-th accepted sample (counted from 0 since reset), `out_valid` is 1 and `out_data` equals accepted sample n-DELAY+1. In an unbroken stream, each sample reaches the output exactly DELAY cycles after it was presented.
- R3: A cycle with `in_valid` = 0 stores nothing and moves no pointer. In the following cycle `out_valid` is 0. The order of later outputs is unchanged.
- R4: Samples stored in the final word of each row, which are written through the second port selected by the next row, come out in order and uncorrupted.
- R5: After the final word of the last row, addressing wraps to word 0 of row 0. The second port of the last row's final word is selected by row 0, so the sequence holds over any number of wraps.
- R6: A synchronous `rst` clears the fill count and both pointers. `out_valid` is 0 in the cycle after reset, and a full refill of DELAY samples is needed again.
- R7: Once filled, `out_valid` in each cycle equals `in_valid` of the cycle before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample present this cycle |
| in_data | input | WIDTH | Input sample |
| out_valid | output | 1 | Delayed sample present |
| out_data | output | WIDTH | Delayed sample |

## Verification
An unbroken counting stream runs across many row ends and wraps. A mismatch there separates a wrong pointer order, a broken second port on row-final words or a bad wrap from correct addressing. A stream with periodic idle cycles shows whether idle cycles wrongly advance the pointers or raise `out_valid`. A pseudo-random stream after a mid-stream reset tells a proper restart of the fill from stale contents leaking out early. Off-by-one errors in the fill threshold show up in the exact cycle where `out_valid` first rises.

// File: rtl/rowdelay_pkg.sv
package rowdelay_pkg;
   // width of an index able to hold values 0 .. n-1 (at least one bit)
   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/rowdelay_ptr.sv
module rowdelay_ptr
   import rowdelay_pkg::*;
#(
   parameter int ROWS = 8,
   parameter int COLS = 4,
   localparam int DELAY = ROWS * COLS,
   localparam int RW = idx_w(ROWS),
   localparam int CW = idx_w(COLS),
   localparam int FW = idx_w(DELAY)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          adv,
   output logic [RW-1:0] row,
   output logic [CW-1:0] col,
   output logic [ROWS-1:0] row_sel,
   output logic          filled
);
   logic [FW-1:0] fill_cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         row      <= '0;
         col      <= '0;
         fill_cnt <= '0;
      end else if (adv) begin
         if (col == CW'(COLS-1)) begin
            col <= '0;
            row <= (row == RW'(ROWS-1)) ? '0 : row + 1'b1;
         end else begin
            col <= col + 1'b1;
         end
         if (fill_cnt != FW'(DELAY-1))
            fill_cnt <= fill_cnt + 1'b1;
      end
   end

   assign filled = (fill_cnt == FW'(DELAY-1));

   always_comb begin
      row_sel = '0;
      row_sel[row] = 1'b1;
   end

   a_r5_wrap: assert property (@(posedge clk) disable iff (rst)
      (adv && row == RW'(ROWS-1) && col == CW'(COLS-1)) |=> (row == '0 && col == '0));
   a_r3_hold: assert property (@(posedge clk) disable iff (rst)
      !adv |=> ($stable(row) && $stable(col)));
endmodule

// File: rtl/rowdelay_array.sv
module rowdelay_array
   import rowdelay_pkg::*;
#(
   parameter int ROWS  = 8,
   parameter int COLS  = 4,
   parameter int WIDTH = 16,
   localparam int RW = idx_w(ROWS),
   localparam int CW = idx_w(COLS)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [ROWS-1:0]  row_sel,
   input  logic [RW-1:0]    row,
   input  logic [CW-1:0]    col,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] rdata
);
   logic [WIDTH-1:0] mem [ROWS][COLS];
   logic [ROWS*COLS-1:0] we_vec;

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      for (genvar c = 0; c < COLS; c++) begin : g_word
         logic we;
         if (c == COLS-1) begin : g_port2
            // second write port, selected by the following row (wrapping)
            assign we = wr_en && row_sel[(r+1) % ROWS] && (col == '0);
         end else begin : g_port1
            // shared-row port: write trails the read column by one
            assign we = wr_en && row_sel[r] && (col == CW'(c+1));
         end
         assign we_vec[r*COLS+c] = we;
         always_ff @(posedge clk) begin
            if (we) mem[r][c] <= wdata;
         end
      end
   end

   assign rdata = mem[row][col];

   a_r4_one_write: assert property (@(posedge clk) disable iff (rst)
      $onehot0(we_vec));
   a_r4_write_when_valid: assert property (@(posedge clk) disable iff (rst)
      wr_en |-> ($countones(we_vec) == 1));
endmodule

// File: rtl/rowdelay_line.sv
module rowdelay_line
   import rowdelay_pkg::*;
#(
   parameter int ROWS  = 8,
   parameter int COLS  = 4,
   parameter int WIDTH = 16,
   localparam int RW = idx_w(ROWS),
   localparam int CW = idx_w(COLS)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [WIDTH-1:0] in_data,
   output logic             out_valid,
   output logic [WIDTH-1:0] out_data
);
   initial begin
      if (ROWS < 2)  $error("rowdelay_line: ROWS must be at least 2");
      if (COLS < 2)  $error("rowdelay_line: COLS must be at least 2");
      if (WIDTH < 1) $error("rowdelay_line: WIDTH must be positive");
   end

   logic [RW-1:0]    row;
   logic [CW-1:0]    col;
   logic [ROWS-1:0]  row_sel;
   logic             filled;
   logic [WIDTH-1:0] rdata;

   rowdelay_ptr #(.ROWS(ROWS), .COLS(COLS)) u_ptr (
      .clk(clk), .rst(rst), .adv(in_valid),
      .row(row), .col(col), .row_sel(row_sel), .filled(filled)
   );

   rowdelay_array #(.ROWS(ROWS), .COLS(COLS), .WIDTH(WIDTH)) u_arr (
      .clk(clk), .rst(rst), .wr_en(in_valid), .row_sel(row_sel),
      .row(row), .col(col), .wdata(in_data), .rdata(rdata)
   );

   always_ff @(posedge clk) begin
      if (rst) out_valid <= 1'b0;
      else     out_valid <= in_valid && filled;
      if (in_valid) out_data <= rdata;
   end

   a_r7_follow: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(in_valid));
   a_r6_after_reset: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !out_valid);
endmodule

// File: tb/rowdelay_line_tb.sv
`timescale 1ns/1ps
module rowdelay_line_tb;
   localparam int ROWS = 8, COLS = 4, WIDTH = 16, DELAY = ROWS*COLS;

   logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
   logic [WIDTH-1:0] in_data = '0;
   logic out_valid;
   logic [WIDTH-1:0] out_data;
   int checks = 0, errors = 0;
   bit done = 0;

   typedef struct { logic v; logic [WIDTH-1:0] d; string tag; } exp_t;
   exp_t exp_q[$];
   logic [WIDTH-1:0] model_q[$];

   always #4 clk = ~clk;

   rowdelay_line #(.ROWS(ROWS), .COLS(COLS), .WIDTH(WIDTH)) u_dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .out_valid(out_valid), .out_data(out_data));

   // driver: applies one cycle and pushes the expected outcome
   task automatic step(input bit v, input logic [WIDTH-1:0] d, input string tag);
      exp_t e;
      @(negedge clk);
      rst = 1'b0; in_valid = v; in_data = d;
      @(posedge clk); #1;
      e.v = 1'b0; e.d = '0; e.tag = v ? tag : "R3";
      if (v) begin
         model_q.push_back(d);
         if (model_q.size() == DELAY) begin
            e.v = 1'b1;
            e.d = model_q.pop_front();
         end
      end
      exp_q.push_back(e);
   endtask

   task automatic do_reset();
      exp_t e;
      @(negedge clk);
      rst = 1'b1; in_valid = 1'b0;
      @(posedge clk); #1;
      model_q.delete();
      e.v = 1'b0; e.d = '0; e.tag = "R6";
      exp_q.push_back(e);
   endtask

   // monitor: compares results away from the active edge
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         checks++;
         if (out_valid !== e.v || (e.v && out_data !== e.d)) begin
            errors++;
            $display("FAIL %s: out_valid=%0b out_data=%0h expected valid=%0b data=%0h",
                     e.tag, out_valid, out_data, e.v, e.d);
         end
      end
   end

   initial begin
      logic [WIDTH-1:0] lfsr;
      repeat (3) @(posedge clk);
      do_reset();                                  // R6 reset state
      for (int i = 0; i < DELAY; i++) step(1'b1, WIDTH'(16'h1000 + i), "R1"); // fill
      for (int i = 0; i < 3*DELAY; i++) step(1'b1, WIDTH'(16'h2000 + i), "R2");
      // long stream: many row ends (R4) and wraps (R5)
      for (int i = 0; i < 5*DELAY + 7; i++) step(1'b1, WIDTH'(16'h4000 + 3*i), (i % COLS == 0) ? "R4" : "R5");
      // idle gaps: R3 / R7
      for (int i = 0; i < 4*DELAY; i++) step((i % 3) != 2, WIDTH'(16'h6000 + i), "R7");
      do_reset();                                  // R6 mid-stream reset
      lfsr = 16'hACE1;
      for (int i = 0; i < DELAY - 1; i++) begin
         step(1'b1, lfsr, "R6");
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      end
      step(1'b0, '0, "R3");
      for (int i = 0; i < 3*DELAY; i++) begin
         step((i % 5) != 4, lfsr, "R2");
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      end
      step(1'b0, '0, "R3");
      @(negedge clk); @(negedge clk);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule